// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Access Controller

This clocked block sits between a simple host request port and an asynchronous 2M x 16 pseudo-static RAM. The host hands over one request at a time with a valid/ready handshake: a single-word write with a two-bit byte mask, or a read of one to eight consecutive words. The controller turns each request into chip-enable, output-enable, write-enable and byte-strobe waveforms, all active low. Every analog timing limit of the memory is a parameter counted in clock cycles.

A read opens the device with a full-length first access. It then stays open and steps only the three low address bits for each later word of the same 8-word page. A burst that reaches the end of a page closes the device and reopens it with a new full access at the next page. A burst is also split when one more page word would hold chip enable low beyond the open-time bound. Read words come back on a one-cycle strobe, in address order. The data bus is split into drive, enable and return signals for the pad ring. The controller enables the drive only while write enable is low.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request pending, chip enable, output enable, write enable and both byte strobes are high, the data drive enable is low and `req_ready` is high.
- R2: A read keeps chip enable and output enable low with the request address for T_ACC cycles. The data bus is sampled at the edge that ends the T_ACC-th cycle, and `rd_data` is presented with a one-cycle `rd_valid` pulse in the next cycle. Every word of a request is returned exactly once, in rising address order.
- R3: Further words of a burst in the same page are read without raising chip enable. Only address bits 2..0 change, and each later word is sampled after T_PC cycles at its address.
- R4: When the next word of a burst lies in the next page, chip enable rises. The next page is then read with a new full T_ACC access.
- R5: Chip enable is never held low for more than T_OPEN consecutive cycles. A burst that would exceed this bound is closed and resumed with a new full access.
- R6: A write holds chip enable and write enable low together for T_WR cycles, with output enable high throughout. The data drive enable is high only while write enable is low.
- R7: `req_be[0]` selects DQ7..0 and `req_be[1]` selects DQ15..8 for a write (1 = write the lane, driven as a low byte strobe). A lane whose bit is 0 keeps its previous memory content. Reads drive both byte strobes low.
- R8: Chip enable stays high for at least T_CEH cycles between any two accesses. Write enable stays high for at least one cycle between two writes.
- R9: The data drive enable is low in the cycle before output enable falls.
- R10: `req_ready` is high only when the controller is idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. `req_len` is the word count minus one for reads. It is ignored for writes, which always store exactly one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address of the request (first word of a burst) |
| req_len | input | 3 | Read word count minus one; ignored for writes |
| req_be | input | 2 | Write lane mask, bit 0 = DQ7..0, bit 1 = DQ15..8 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle strobe for a returned read word |
| rd_data | output | 16 | Returned read word |
| mem_addr | output | 21 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data returned from the memory |

## Verification
The bench builds the controller with the cycle counts that an 8 ns clock gives for the device limits: T_ACC = 9, T_PC = 3, T_WR = 9 and T_CEH = 2. T_OPEN is shortened from 1250 to 20 cycles. With that value an aligned 8-word burst fits only four words per opening, so the open-time split happens within a few dozen cycles. In the same runs the page-end split is reached by bursts that start at offsets 6 and 14. The behavioural memory model returns a poison value until its access and page windows have elapsed. It also checks every pulse width, so a sample taken too early or a gap that is too short shows up as a data mismatch or a timing violation.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_FIRST = 3'd1,
    ST_RD_PAGE  = 3'd2,
    ST_WR       = 3'd3,
    ST_GAP      = 3'd4
  } psram_st_e;

  // Words left in the page counting the current one.
  function automatic int unsigned words_to_page_end(input int unsigned offset,
                                                    input int unsigned page_words);
    return page_words - offset;
  endfunction

  // True when one more page word still keeps the open time inside the bound.
  function automatic logic fits_another(input int unsigned used_cycles,
                                        input int unsigned page_cycles,
                                        input int unsigned open_limit);
    return (used_cycles + page_cycles) <= open_limit;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq
  import psram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3,
  parameter int T_ACC  = 9,
  parameter int T_PC   = 3,
  parameter int T_WR   = 9,
  parameter int T_CEH  = 2,
  parameter int T_OPEN = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PAGE_W-1:0] req_len,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output psram_st_e         state,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [1:0]        be_q,
  output logic              cap_evt,
  output logic              close_evt,
  output logic              wr_end_evt
);

  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int CNT_MAX    = max4(T_ACC, T_PC, T_WR, T_CEH);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int OPEN_W     = $clog2(T_OPEN + 1);
  localparam int LEFT_W     = PAGE_W + 1;
  localparam logic [CNT_W-1:0] LIM_ACC = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LIM_PC  = CNT_W'(T_PC - 1);
  localparam logic [CNT_W-1:0] LIM_WR  = CNT_W'(T_WR - 1);
  localparam logic [CNT_W-1:0] LIM_CEH = CNT_W'(T_CEH - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic [OPEN_W-1:0] open_cnt;
  logic [LEFT_W-1:0] left_q;
  logic              phase_end;
  logic              in_rd;
  logic              more;
  logic              stay_open;
  logic              accept;

  always_comb begin
    case (state)
      ST_RD_FIRST: lim = LIM_ACC;
      ST_RD_PAGE:  lim = LIM_PC;
      ST_WR:       lim = LIM_WR;
      ST_GAP:      lim = LIM_CEH;
      default:     lim = '0;
    endcase
  end

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign phase_end  = (state != ST_IDLE) && (cnt == lim);
  assign in_rd      = (state == ST_RD_FIRST) || (state == ST_RD_PAGE);
  assign more       = left_q > LEFT_W'(1);
  assign stay_open  = more
                   && (words_to_page_end(32'(addr_q[PAGE_W-1:0]), PAGE_WORDS) > 32'd1)
                   && fits_another(32'(open_cnt) + 32'd1, T_PC, T_OPEN);
  assign cap_evt    = in_rd && phase_end;
  assign close_evt  = cap_evt && !stay_open;
  assign wr_end_evt = (state == ST_WR) && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      open_cnt <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
    end else if (state == ST_IDLE) begin
      cnt      <= '0;
      open_cnt <= '0;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        if (req_write) begin
          left_q <= '0;
          state  <= ST_WR;
        end else begin
          left_q <= LEFT_W'(req_len) + LEFT_W'(1);
          state  <= ST_RD_FIRST;
        end
      end
    end else begin
      cnt      <= phase_end ? '0 : cnt + CNT_W'(1);
      open_cnt <= in_rd ? open_cnt + OPEN_W'(1) : '0;
      if (phase_end) begin
        case (state)
          ST_RD_FIRST, ST_RD_PAGE: begin
            left_q <= left_q - LEFT_W'(1);
            if (more) addr_q <= addr_q + ADDR_W'(1);
            state <= stay_open ? ST_RD_PAGE : ST_GAP;
          end
          ST_WR:   state <= ST_GAP;
          ST_GAP:  state <= (left_q != '0) ? ST_RD_FIRST : ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/psram_pins.sv
`timescale 1ns/1ps
module psram_pins
  import psram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  psram_st_e         state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [1:0]        be_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  logic rd_on;
  logic wr_on;

  assign rd_on     = (state == ST_RD_FIRST) || (state == ST_RD_PAGE);
  assign wr_on     = (state == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_ce_n  = !(rd_on || wr_on);
  assign mem_oe_n  = !rd_on;
  assign mem_we_n  = !wr_on;
  assign mem_lb_n  = !(rd_on || (wr_on && be_q[0]));
  assign mem_ub_n  = !(rd_on || (wr_on && be_q[1]));
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = wr_on;

endmodule

// File: rtl/psram_rdcap.sv
`timescale 1ns/1ps
module psram_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_evt;
      if (cap_evt) rd_data <= mem_dq_i;
    end
  end

endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3,
  parameter int T_ACC  = 9,
  parameter int T_PC   = 3,
  parameter int T_WR   = 9,
  parameter int T_CEH  = 2,
  parameter int T_OPEN = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PAGE_W-1:0] req_len,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  psram_st_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q;
  logic              cap_evt;
  logic              close_evt;
  logic              wr_end_evt;

  psram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .T_ACC(T_ACC), .T_PC(T_PC), .T_WR(T_WR), .T_CEH(T_CEH), .T_OPEN(T_OPEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .state(state), .addr_q(addr_q),
    .wdata_q(wdata_q), .be_q(be_q),
    .cap_evt(cap_evt), .close_evt(close_evt), .wr_end_evt(wr_end_evt)
  );

  psram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state), .addr_q(addr_q), .wdata_q(wdata_q), .be_q(be_q),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  psram_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .mem_dq_i(mem_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/psram_chk.sv
`timescale 1ns/1ps
module psram_chk #(
  parameter int ADDR_W = 21,
  parameter int PAGE_W = 3,
  parameter int T_CEH  = 2,
  parameter int T_OPEN = 1250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic              cap_evt,
  input logic              close_evt,
  input logic              wr_end_evt
);

  localparam int RUN_W = $clog2(T_OPEN + T_CEH + 2);

  logic [RUN_W-1:0] low_run;
  logic [RUN_W-1:0] high_run;

  // low_run: completed low cycles of chip enable; high_run: completed high cycles (saturating)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= RUN_W'(T_CEH);
    end else if (mem_ce_n) begin
      low_run  <= '0;
      if (high_run < RUN_W'(T_CEH)) high_run <= high_run + RUN_W'(1);
    end else begin
      low_run  <= low_run + RUN_W'(1);
      high_run <= '0;
    end
  end

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_capture_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (!mem_ce_n && !mem_oe_n && mem_we_n));

  a_r2_strobe_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rd_valid);

  a_r3_page_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |->
      ((mem_addr >> PAGE_W) == ($past(mem_addr) >> PAGE_W)));

  a_r4_close_raises_ce: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> mem_ce_n);

  a_r5_open_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (low_run < RUN_W'(T_OPEN)));

  a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r6_drive_only_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  a_r6_write_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end_evt |=> (mem_we_n && mem_ce_n && !mem_dq_oe));

  a_r8_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (high_run >= RUN_W'(T_CEH)));

  a_r9_bus_released_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

bind psram_ctrl psram_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .T_CEH(T_CEH), .T_OPEN(T_OPEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .cap_evt(cap_evt), .close_evt(close_evt), .wr_end_evt(wr_end_evt)
);

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;

  localparam int CLK_NS = 8;
  function automatic int ns2cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int C_ACC  = ns2cyc(65);
  localparam int C_PC   = ns2cyc(20);
  localparam int C_WC   = ns2cyc(65);
  localparam int C_WP   = ns2cyc(50);
  localparam int C_CEH  = ns2cyc(10);
  localparam int C_WEH  = ns2cyc(6);
  localparam int C_OPEN = 20;
  localparam int WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i = 16'hDEAD;

  psram_ctrl #(
    .T_ACC(C_ACC), .T_PC(C_PC), .T_WR(C_WC), .T_CEH(C_CEH), .T_OPEN(C_OPEN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_be(req_be), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int opens = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Golden contents (bench view) and model array (what the pins wrote)
  logic [15:0] gold [int unsigned];
  logic [15:0] marr [int unsigned];
  logic [15:0] expq [$];
  string       tagq [$];

  function automatic logic [15:0] gget(input int unsigned a);
    return gold.exists(a) ? gold[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] mget(input int unsigned a);
    return marr.exists(a) ? marr[a] : 16'h0000;
  endfunction

  // Behavioural memory model with pulse-width checks
  int ce_run, ce_hi_run, we_run, we_hi_run, addr_age;
  bit wr_cyc;
  logic p_ce_n, p_we_n, p_dq_oe;
  logic [20:0] p_addr, w_addr;
  logic [15:0] w_data;
  logic w_lb_n, w_ub_n;

  always @(negedge clk) begin
    if (!rst_n) begin
      ce_run = 0; ce_hi_run = C_CEH; we_run = 0; we_hi_run = C_WEH; addr_age = 0;
      wr_cyc = 0; p_ce_n = 1; p_we_n = 1; p_dq_oe = 0; p_addr = '0;
      mem_dq_i <= 16'hDEAD;
    end else begin
      if (!mem_ce_n && p_ce_n) begin
        chk(ce_hi_run >= C_CEH, "R8", "chip enable high gap", ce_hi_run, C_CEH);
        opens++; ce_run = 0; wr_cyc = 0;
      end
      if (mem_ce_n && !p_ce_n) begin
        if (wr_cyc) chk(ce_run >= C_WC, "R6", "write cycle length", ce_run, C_WC);
        else        chk(ce_run >= C_ACC, "R2", "read cycle length", ce_run, C_ACC);
        chk(ce_run <= C_OPEN, "R5", "open time", ce_run, C_OPEN);
      end
      if (!mem_ce_n) begin ce_run++; ce_hi_run = 0; end
      else ce_hi_run++;
      if (!mem_ce_n && !p_ce_n && mem_addr != p_addr)
        chk((mem_addr >> 3) == (p_addr >> 3), "R3", "page step left the page",
            32'(mem_addr), 32'(p_addr));
      if (!mem_we_n) begin
        if (p_we_n) chk(we_hi_run >= C_WEH, "R8", "write enable high gap", we_hi_run, C_WEH);
        if (!mem_oe_n) chk(0, "R6", "output enable low during write", 0, 1);
        wr_cyc = 1; we_run++; we_hi_run = 0;
        w_addr = mem_addr; w_data = mem_dq_o; w_lb_n = mem_lb_n; w_ub_n = mem_ub_n;
      end else begin
        we_hi_run++;
      end
      if (mem_we_n && !p_we_n) begin
        chk(we_run >= C_WP, "R6", "write pulse width", we_run, C_WP);
        begin
          logic [15:0] v;
          v = mget(32'(w_addr));
          if (!w_lb_n) v[7:0] = w_data[7:0];
          if (!w_ub_n) v[15:8] = w_data[15:8];
          marr[32'(w_addr)] = v;
        end
        we_run = 0;
      end
      if (mem_dq_oe && mem_we_n) chk(0, "R6", "bus driven with write enable high", 1, 0);
      if (!mem_oe_n && p_dq_oe) chk(0, "R9", "bus driven just before output enable", 1, 0);
      if (mem_addr != p_addr) addr_age = 1; else addr_age++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n && ce_run >= C_ACC && addr_age >= C_PC) begin
        logic [15:0] r;
        r = mget(32'(mem_addr));
        if (mem_lb_n) r[7:0] = 8'hAD;
        if (mem_ub_n) r[15:8] = 8'hDE;
        mem_dq_i <= r;
      end else begin
        mem_dq_i <= 16'hDEAD;
      end
      p_ce_n = mem_ce_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe; p_addr = mem_addr;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(0, "R2", "unexpected read strobe", 32'(rd_data), 0);
      else begin
        logic [15:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rd_data == e, t, "read data", 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic send(input bit wr, input logic [20:0] a, input logic [15:0] d,
                      input logic [1:0] be, input logic [2:0] len);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", "ready while busy", 32'(req_ready), 0);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] be, input logic [2:0] len);
    logic [15:0] v;
    v = gget(32'(a));
    if (be[0]) v[7:0] = d[7:0];
    if (be[1]) v[15:8] = d[15:8];
    gold[32'(a)] = v;
    send(1'b1, a, d, be, len);
  endtask

  task automatic do_read(input logic [20:0] a, input logic [2:0] len, input string tag);
    for (int i = 0; i <= int'(len); i++) begin
      expq.push_back(gget(32'(a) + 32'(i)));
      tagq.push_back(tag);
    end
    send(1'b0, a, 16'h0, 2'b00, len);
  endtask

  task automatic drain();
    while (expq.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_opens(input logic [20:0] a, input logic [2:0] len,
                            input string tag, input int exp_opens);
    int o0;
    drain();
    o0 = opens;
    do_read(a, len, tag);
    drain();
    chk(opens - o0 == exp_opens, tag, "chip enable openings", opens - o0, exp_opens);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      chk(0, "R2", "watchdog expired", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
        "R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1", "idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);

    // Fill page 0x100..0x10F with full-word writes (R6)
    for (int i = 0; i < 16; i++) do_write(21'h100 + 21'(i), 16'hA000 + 16'(i * 17), 2'b11, 3'd0);

    // Byte-masked writes (R7)
    do_write(21'h200, 16'h1234, 2'b11, 3'd0);
    do_write(21'h200, 16'hFFEE, 2'b01, 3'd0);
    do_write(21'h201, 16'h5678, 2'b11, 3'd0);
    do_write(21'h201, 16'hAB00, 2'b10, 3'd0);
    do_write(21'h202, 16'h9999, 2'b11, 3'd0);
    do_write(21'h202, 16'h0000, 2'b00, 3'd0);
    // A write with a nonzero length field stores one word only (R10)
    do_write(21'h300, 16'h4444, 2'b11, 3'd7);

    do_read(21'h200, 3'd0, "R7");
    do_read(21'h201, 3'd0, "R7");
    do_read(21'h202, 3'd0, "R7");
    do_read(21'h300, 3'd0, "R10");
    do_read(21'h301, 3'd0, "R10");

    read_opens(21'h105, 3'd0, "R2", 1);
    read_opens(21'h102, 3'd2, "R3", 1);
    read_opens(21'h100, 3'd7, "R5", 2);
    read_opens(21'h106, 3'd3, "R4", 2);
    read_opens(21'h10E, 3'd3, "R4", 2);

    // Back-to-back writes then a read spanning them (R8 gaps checked by the model)
    do_write(21'h108, 16'h0F0F, 2'b11, 3'd0);
    do_write(21'h109, 16'hF0F0, 2'b11, 3'd0);
    read_opens(21'h108, 3'd1, "R3", 1);

    drain();
    chk(expq.size() == 0, "R2", "words still outstanding", expq.size(), 0);
    finish_run();
  end

endmodule